// File: doc/BRIEF.md
# Link-Aware Transmit Stream Router

This block sits between the host DMA outbound stream and a serial link transmitter that carries four virtual channels. It looks at each frame as it arrives, tags the frame's leading beat with a start-of-frame flag, and steers the whole frame to the channel output selected by the destination field on that leading beat. The path is combinational and adds no storage stage. An input beat therefore reaches its channel in the same cycle, and back-pressure from that channel goes straight back to the source.

When the link is not ready, the block does not stall the DMA. It accepts and discards whole frames. A frame whose destination names no existing channel is also discarded. Drop and forward decisions are made only where a frame begins. A frame that has started out of a channel always finishes there, and a frame that is being discarded is discarded to its end. As a result, no channel ever sees a frame that is missing its head or its tail.

Top module: `tx_stream_router`

## Requirements
- R1: If `link_up` is low when a frame's first beat is presented, no beat of that frame appears on any output (`m_tvalid` stays 0 for the whole frame).
- R2: Every beat of a discarded frame is accepted at once (`s_tready` high while `s_tvalid` is high), whatever the `m_tready` values are.
- R3: Once `link_up` is high again, the next frame that starts is forwarded normally.
- R4: If `link_up` falls after a forwarded frame has started, the remaining beats of that frame, up to and including the `s_tlast` beat, are still forwarded to the same channel.
- R5: If `link_up` rises while a frame is being discarded, the rest of that frame is still discarded.
- R6: `m_tuser` bit 1 is 1 on the first beat of each forwarded frame and 0 on every other beat. `m_tuser` bit 0, `m_tdata` and `m_tlast` pass through unchanged in the same cycle.
- R7: A frame whose first-beat `s_tdest` is 0 to 3 is presented only on `m_tvalid[s_tdest]` (bit i of `m_tvalid` is channel i).
- R8: A frame whose first-beat `s_tdest` is 4 or greater is discarded in full, as in R1 and R2.
- R9: The channel chosen on the first beat is kept until the `s_tlast` beat, even if `s_tdest` changes on later beats.
- R10: While a frame is being forwarded, `s_tready` equals `m_tready` of the selected channel in the same cycle, and the output is valid in the same cycle as the input (no added latency).
- R11: After reset no output is valid, and the first beat accepted after reset is treated as the start of a frame.
- R12: Once a first beat has been presented, its forward or drop decision is fixed. A change of `link_up` while that beat waits on a stalled channel does not withdraw `m_tvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link ready for traffic |
| s_tdata | input | DATA_W (64) | Input beat data |
| s_tuser | input | USER_W (2) | Input sideband; bit 0 passes through |
| s_tdest | input | DEST_W (4) | Destination channel of the frame |
| s_tlast | input | 1 | Last beat of frame |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| m_tdata | output | DATA_W (64) | Data shared by all channel outputs |
| m_tuser | output | USER_W (2) | Sideband; bit 1 is start of frame |
| m_tlast | output | 1 | Last beat, shared by all channels |
| m_tvalid | output | NUM_CH (4) | Per-channel valid, bit i = channel i |
| m_tready | input | NUM_CH (4) | Per-channel ready, bit i = channel i |

## Verification
Most of the state here is a latched decision, so a wrong internal state shows up at the ports in the very next cycle. A stale start-of-frame flag puts bit 1 of `m_tuser` on a middle beat, or leaves it off a leading beat. A lost route latch moves a frame's tail to another `m_tvalid` bit. A drop decision that is not held lets a frame show a tail with no head, or a head with no tail. The bench changes `link_up` and `s_tdest` at each beat position inside frames and checks every beat at the ports.

// File: rtl/tx_stream_router.sv
module tx_stream_router #(
  parameter int DATA_W = 64,
  parameter int USER_W = 2,
  parameter int DEST_W = 4,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [USER_W-1:0] s_tuser,
  input  logic [DEST_W-1:0] s_tdest,
  input  logic              s_tlast,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [USER_W-1:0] m_tuser,
  output logic              m_tlast,
  output logic [NUM_CH-1:0] m_tvalid,
  input  logic [NUM_CH-1:0] m_tready
);

  localparam int RW      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SOF_BIT = 1;

  logic          lock_q, drop_q, started_q;
  logic [RW-1:0] route_q;
  logic          fresh_drop, drop, fwd, hs;
  logic [RW-1:0] route;

  assign fresh_drop = !link_up || (s_tdest >= DEST_W'(NUM_CH));
  assign drop  = lock_q ? drop_q  : fresh_drop;
  assign route = lock_q ? route_q : s_tdest[RW-1:0];
  assign fwd   = !drop;

  assign s_tready = drop ? 1'b1 : m_tready[route];
  assign hs       = s_tvalid && s_tready;

  assign m_tdata = s_tdata;
  assign m_tlast = s_tlast;

  always_comb begin
    m_tuser          = s_tuser;
    m_tuser[SOF_BIT] = !started_q;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign m_tvalid[i] = s_tvalid && fwd && (route == RW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      drop_q    <= 1'b0;
      route_q   <= '0;
      started_q <= 1'b0;
    end else begin
      if (s_tvalid && !lock_q) begin
        lock_q  <= 1'b1;
        drop_q  <= fresh_drop;
        route_q <= s_tdest[RW-1:0];
      end
      if (hs) begin
        started_q <= !s_tlast;
        if (s_tlast) lock_q <= 1'b0;
      end
    end
  end

  // R7
  one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_tvalid));

  // R1
  flush_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && !lock_q && !link_up) |-> (s_tready && m_tvalid == '0));

  // R8
  bad_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && !lock_q && s_tdest >= DEST_W'(NUM_CH)) |-> (s_tready && m_tvalid == '0));

  // R10
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|m_tvalid) |-> (s_tready == |(m_tvalid & m_tready)));

  // R6
  sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(m_tvalid & m_tready) && !s_tlast) |=> !m_tuser[SOF_BIT]);

  // R9
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(m_tvalid & m_tready) && !s_tlast) |=> (m_tvalid == '0 || m_tvalid == $past(m_tvalid)));

  // R12
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|m_tvalid && !s_tready) |=> (!s_tvalid || m_tvalid == $past(m_tvalid)));

endmodule

// File: tb/sim_tx_stream_router.sv
`timescale 1ns/1ps
module sim_tx_stream_router;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        link_up = 0;
  logic [63:0] s_tdata = '0;
  logic [1:0]  s_tuser = '0;
  logic [3:0]  s_tdest = '0;
  logic        s_tlast = 0;
  logic        s_tvalid = 0;
  logic        s_tready;
  logic [63:0] m_tdata;
  logic [1:0]  m_tuser;
  logic        m_tlast;
  logic [3:0]  m_tvalid;
  logic [3:0]  m_tready = 4'hF;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  tx_stream_router u0 (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tdest(s_tdest), .s_tlast(s_tlast),
    .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Present one beat (inputs settle 1 ns after an edge), check it, let it be accepted.
  // ch < 0: beat must be dropped.
  task automatic beat(input logic [63:0] d, input logic [3:0] dst, input bit lst,
                      input bit u0b, input int ch, input bit sof, input string rq);
    s_tdata = d; s_tdest = dst; s_tlast = lst; s_tuser = {1'b0, u0b}; s_tvalid = 1;
    #1;
    if (ch < 0) begin
      chk(m_tvalid == 4'b0, {rq, " drop valid"}, m_tvalid, 0);
      chk(s_tready == 1'b1, {rq, " drop ready"}, s_tready, 1);
    end else begin
      chk(m_tvalid == 4'(1 << ch), {rq, " route"}, m_tvalid, 4'(1 << ch));
      chk(m_tuser == {sof, u0b}, {rq, " tuser"}, m_tuser, {sof, u0b});
      chk(m_tdata == d && m_tlast == lst, {rq, " data/last"}, m_tdata, d);
      chk(s_tready == m_tready[ch], "R10 ready follow", s_tready, m_tready[ch]);
    end
    @(posedge clk); #1;
    s_tvalid = 0;
  endtask

  task automatic t_reset();
    chk(m_tvalid == 4'b0, "R11 reset valid", m_tvalid, 0);
  endtask

  task automatic t_route();
    link_up = 1;
    for (int c = 0; c < 4; c++) begin
      beat(64'hA000 + c, 4'(c), 0, 1, c, 1, c == 0 ? "R11 first after reset" : "R7");
      beat(64'hB000 + c, 4'(c), 0, 0, c, 0, "R6 mid");
      beat(64'hC000 + c, 4'(c), 1, 1, c, 0, "R6 last");
    end
  endtask

  task automatic t_bad_dest();
    beat(64'h51, 4'd5, 0, 0, -1, 0, "R8");
    beat(64'h52, 4'd1, 1, 0, -1, 0, "R8 tail");
    beat(64'hF1, 4'd15, 1, 0, -1, 0, "R8 single");
    beat(64'h61, 4'd2, 1, 0, 2, 1, "R6 after drop");
  endtask

  task automatic t_flush();
    link_up = 0; m_tready = 4'h0;
    beat(64'h71, 4'd0, 0, 0, -1, 0, "R1");
    beat(64'h72, 4'd0, 0, 0, -1, 0, "R2");
    beat(64'h73, 4'd0, 1, 0, -1, 0, "R2");
    m_tready = 4'hF; link_up = 1;
    beat(64'h74, 4'd3, 0, 0, 3, 1, "R3");
    beat(64'h75, 4'd3, 1, 0, 3, 0, "R3");
  endtask

  task automatic t_mid_link();
    beat(64'h81, 4'd1, 0, 0, 1, 1, "R4");
    link_up = 0;
    beat(64'h82, 4'd1, 0, 0, 1, 0, "R4");
    beat(64'h83, 4'd1, 1, 0, 1, 0, "R4");
    beat(64'h84, 4'd1, 0, 0, -1, 0, "R1");
    link_up = 1;
    beat(64'h85, 4'd1, 0, 0, -1, 0, "R5");
    beat(64'h86, 4'd1, 1, 0, -1, 0, "R5");
    beat(64'h87, 4'd1, 1, 0, 1, 1, "R3");
  endtask

  task automatic t_dest_change();
    beat(64'h91, 4'd2, 0, 0, 2, 1, "R9");
    beat(64'h92, 4'd0, 0, 0, 2, 0, "R9");
    beat(64'h93, 4'd7, 1, 0, 2, 0, "R9");
  endtask

  task automatic t_stall();
    m_tready = 4'b1101;
    s_tdata = 64'hD1; s_tdest = 4'd1; s_tlast = 0; s_tuser = 2'b00; s_tvalid = 1;
    #1;
    chk(s_tready == 1'b0, "R10 stalled", s_tready, 0);
    chk(m_tvalid == 4'b0010, "R10 valid", m_tvalid, 4'b0010);
    @(posedge clk); #1;
    link_up = 0; #1;
    chk(m_tvalid == 4'b0010, "R12 valid held", m_tvalid, 4'b0010);
    chk(s_tready == 1'b0, "R12 still stalled", s_tready, 0);
    @(posedge clk); #1;
    m_tready = 4'hF; #1;
    chk(s_tready == 1'b1 && m_tuser[1], "R10 released", {s_tready, m_tuser[1]}, 2'b11);
    @(posedge clk); #1;
    s_tvalid = 0;
    beat(64'hD2, 4'd1, 1, 0, 1, 0, "R4 tail");
    link_up = 1;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    @(posedge clk); #1;
    t_route();
    t_bad_dest();
    t_flush();
    t_mid_link();
    t_dest_change();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule